// File: doc/BRIEF.md
# Data Bus Tenure Grant Qualifier

This block holds data-bus ownership for one master on a split-transaction processor bus. It watches an active-low data-bus grant and decides on each rising clock edge whether that grant counts as a qualified grant for the pending data tenure. While the master owns the bus, the block drives an active-low busy output. It counts transfer acknowledges to find the end of each tenure: one acknowledge ends a single-beat tenure and `BURST_BEATS` acknowledges end a burst.

Two operating modes are selected by a level input. In normal mode, a grant qualifies only while no other master shows busy. In streaming mode, the block ignores the busy level of the other masters, so the system uses the grant alone to prevent collisions. A grant that is left parked low is accepted. A grant that arrives together with the final acknowledge chains straight into the next tenure, but only when both the finishing tenure and the pending one are burst reads. A second level input selects no-retry operation. When it is clear, an active-low retry input restarts the beat count and holds the tenure open.

The requester presents its pending tenure as a valid level with burst and read qualifiers. It must withdraw or replace that request before the clock edge that follows the cycle in which `take_o` is seen high.

Top module: `dbt_tenure_ctrl`

## Requirements
- R1: After a synchronous reset, `busy_n_o` is 1, `take_o` and `done_o` are 0, and `beat_o` is 0.
- R2: In normal mode (`stream_mode_i`=0), an idle block starts a tenure at an edge where `grant_n_i`=0, `ext_busy_n_i`=1 and `req_valid_i`=1. After that edge `busy_n_o` is 0 and `take_o` is 1 for one cycle. If `ext_busy_n_i`=0 at that edge, no tenure starts.
- R3: In streaming mode (`stream_mode_i`=1), `ext_busy_n_i` has no effect. An idle block starts a tenure at an edge where `grant_n_i`=0 and `req_valid_i`=1.
- R4: In streaming mode, a grant held low for many cycles while no request is pending qualifies a request that arrives later, and the grant does not have to toggle.
- R5: While `grant_n_i`=1, an idle block never starts a tenure in either mode.
- R6: Each acknowledge (`xfer_ack_n_i`=0) during a tenure advances `beat_o` by one. A tenure with burst=0 ends on its first acknowledge, and a tenure with burst=1 ends on its `BURST_BEATS`-th acknowledge. After the edge of the final acknowledge, `done_o` is 1 for one cycle and, unless R7 applies, `busy_n_o` is 1 and `beat_o` is 0.
- R7: In streaming mode, if the final acknowledge of a burst read (burst=1, read=1) meets `grant_n_i`=0 and a pending burst read, then `busy_n_o` stays 0, `take_o` and `done_o` pulse, and `beat_o` returns to 0 for the new tenure.
- R8: Under any other combination at the final acknowledge (normal mode, the current tenure not a burst read, or the pending tenure not a burst read), the bus is released with `take_o`=0.
- R9: With `no_retry_i`=0, `retry_n_i`=0 during a tenure sets `beat_o` to 0. An acknowledge in that cycle is not counted, and `busy_n_o` stays 0.
- R10: With `no_retry_i`=1, `retry_n_i` has no effect, and acknowledges keep counting.
- R11: While idle, acknowledges and retries have no effect: `beat_o` stays 0 and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_mode_i | input | 1 | 1 selects streaming mode |
| no_retry_i | input | 1 | 1 makes the block ignore `retry_n_i` |
| req_valid_i | input | 1 | A data tenure is pending |
| req_burst_i | input | 1 | Pending tenure is a burst (1) or single beat (0) |
| req_read_i | input | 1 | Pending tenure is a read (1) or write (0) |
| grant_n_i | input | 1 | Active-low data bus grant |
| ext_busy_n_i | input | 1 | Active-low busy from other masters |
| xfer_ack_n_i | input | 1 | Active-low transfer acknowledge |
| retry_n_i | input | 1 | Active-low data retry |
| busy_n_o | output | 1 | Active-low data bus busy, registered |
| take_o | output | 1 | One-cycle pulse: pending tenure accepted |
| done_o | output | 1 | One-cycle pulse: a tenure completed its final beat |
| beat_o | output | $clog2(BURST_BEATS) | Beat index of the current tenure |

## Verification
The assertions check, on every cycle, the local rules that can be seen at the ports:
- a start is blocked while the grant is high, or while another master is busy in normal mode;
- `take_o` lasts a single cycle and only ever appears with busy asserted;
- a completion without a chain releases the bus;
- `beat_o` is zero whenever the block is idle;
- a retry clears the count and keeps busy held;
- a chain happens only in streaming mode and only with a pending burst read.

Other behaviours depend on what the tenure was when it started, so only the bench's scenarios can show them. These are the exact beat on which a single or burst tenure ends, acceptance of a parked grant, the requirement that the finishing tenure is itself a burst read, and the ignored retry in no-retry mode. The bench compares against a cycle model of these rules.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  // Kind of data tenure: burst length class and direction.
  typedef struct packed {
    logic burst;
    logic read;
  } tenure_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OWN  = 1'b1
  } own_state_e;

  function automatic logic is_burst_read(tenure_t t);
    return t.burst & t.read;
  endfunction

endpackage

// File: rtl/dbt_qualify.sv
module dbt_qualify
  import dbt_pkg::*;
(
  input  logic    stream_mode,
  input  logic    grant_n,
  input  logic    ext_busy_n,
  input  logic    req_valid,
  input  tenure_t req_kind,
  input  logic    owning,
  input  logic    final_beat,
  input  tenure_t cur_kind,
  output logic    start_idle,
  output logic    chain
);

  logic grant_seen;
  logic bus_free;

  always_comb begin
    grant_seen = ~grant_n & req_valid;
    // Streaming mode leaves collision avoidance to the grant alone.
    bus_free   = stream_mode | ext_busy_n;
    start_idle = ~owning & grant_seen & bus_free;
    chain      = owning & final_beat & stream_mode & grant_seen &
                 is_burst_read(cur_kind) & is_burst_read(req_kind);
  end

endmodule

// File: rtl/dbt_beat_counter.sv
module dbt_beat_counter #(
  parameter int BURST_BEATS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic                           advance,
  input  logic                           is_burst,
  output logic [$clog2(BURST_BEATS)-1:0] count,
  output logic                           at_last
);

  localparam int CNT_W = $clog2(BURST_BEATS);
  localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_BEATS - 1);

  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx = is_burst ? BURST_LAST : '0;
    at_last  = (count == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (advance) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/dbt_tenure_fsm.sv
module dbt_tenure_fsm
  import dbt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_idle,
  input  logic    chain,
  input  logic    final_beat,
  input  tenure_t req_kind,
  output logic    owning,
  output tenure_t cur_kind,
  output logic    busy_n,
  output logic    take,
  output logic    done
);

  own_state_e state_q;
  own_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_idle) state_d = ST_OWN;
      ST_OWN:  if (final_beat && !chain) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign owning = (state_q == ST_OWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cur_kind <= '0;
      busy_n   <= 1'b1;
      take     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_n  <= (state_d != ST_OWN);
      take    <= start_idle | chain;
      done    <= final_beat;
      if (start_idle || chain) begin
        cur_kind <= req_kind;
      end
    end
  end

endmodule

// File: rtl/dbt_tenure_ctrl.sv
module dbt_tenure_ctrl
  import dbt_pkg::*;
#(
  parameter int BURST_BEATS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           stream_mode_i,
  input  logic                           no_retry_i,
  input  logic                           req_valid_i,
  input  logic                           req_burst_i,
  input  logic                           req_read_i,
  input  logic                           grant_n_i,
  input  logic                           ext_busy_n_i,
  input  logic                           xfer_ack_n_i,
  input  logic                           retry_n_i,
  output logic                           busy_n_o,
  output logic                           take_o,
  output logic                           done_o,
  output logic [$clog2(BURST_BEATS)-1:0] beat_o
);

  tenure_t req_kind;
  tenure_t cur_kind;
  logic    owning;
  logic    retry_hit;
  logic    ack_hit;
  logic    at_last;
  logic    final_beat;
  logic    start_idle;
  logic    chain;
  logic    cnt_clear;

  always_comb begin
    req_kind.burst = req_burst_i;
    req_kind.read  = req_read_i;
    retry_hit      = owning & ~no_retry_i & ~retry_n_i;
    ack_hit        = owning & ~xfer_ack_n_i & ~retry_hit;
    final_beat     = ack_hit & at_last;
    cnt_clear      = start_idle | retry_hit | final_beat;
  end

  dbt_qualify u_qualify (
    .stream_mode (stream_mode_i),
    .grant_n     (grant_n_i),
    .ext_busy_n  (ext_busy_n_i),
    .req_valid   (req_valid_i),
    .req_kind    (req_kind),
    .owning      (owning),
    .final_beat  (final_beat),
    .cur_kind    (cur_kind),
    .start_idle  (start_idle),
    .chain       (chain)
  );

  dbt_beat_counter #(
    .BURST_BEATS (BURST_BEATS)
  ) u_counter (
    .clk      (clk),
    .rst      (rst),
    .clear    (cnt_clear),
    .advance  (ack_hit),
    .is_burst (cur_kind.burst),
    .count    (beat_o),
    .at_last  (at_last)
  );

  dbt_tenure_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_idle (start_idle),
    .chain      (chain),
    .final_beat (final_beat),
    .req_kind   (req_kind),
    .owning     (owning),
    .cur_kind   (cur_kind),
    .busy_n     (busy_n_o),
    .take       (take_o),
    .done       (done_o)
  );

endmodule

// File: rtl/dbt_tenure_ctrl_chk.sv
module dbt_tenure_ctrl_chk #(
  parameter int BURST_BEATS = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           stream_mode_i,
  input logic                           no_retry_i,
  input logic                           req_burst_i,
  input logic                           req_read_i,
  input logic                           grant_n_i,
  input logic                           ext_busy_n_i,
  input logic                           retry_n_i,
  input logic                           busy_n_o,
  input logic                           take_o,
  input logic                           done_o,
  input logic [$clog2(BURST_BEATS)-1:0] beat_o
);

  p_blocked_by_other_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_n_o && !stream_mode_i && !ext_busy_n_i) |=> busy_n_o);

  p_take_with_busy_r2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !busy_n_o);

  p_take_single_r2: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);

  p_no_grant_no_start_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_n_o && grant_n_i) |=> busy_n_o);

  p_done_releases_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && !take_o) |-> busy_n_o);

  p_chain_burst_read_r7: assert property (@(posedge clk) disable iff (rst)
    (take_o && $past(!busy_n_o)) |->
      ($past(stream_mode_i) && $past(req_burst_i) && $past(req_read_i)));

  p_retry_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_n_o && !no_retry_i && !retry_n_i) |=>
      (beat_o == '0 && !busy_n_o && !done_o));

  p_idle_beat_zero_r11: assert property (@(posedge clk) disable iff (rst)
    busy_n_o |-> (beat_o == '0));

endmodule

bind dbt_tenure_ctrl dbt_tenure_ctrl_chk #(.BURST_BEATS(BURST_BEATS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .stream_mode_i (stream_mode_i),
  .no_retry_i    (no_retry_i),
  .req_burst_i   (req_burst_i),
  .req_read_i    (req_read_i),
  .grant_n_i     (grant_n_i),
  .ext_busy_n_i  (ext_busy_n_i),
  .retry_n_i     (retry_n_i),
  .busy_n_o      (busy_n_o),
  .take_o        (take_o),
  .done_o        (done_o),
  .beat_o        (beat_o)
);

// File: tb/dbt_tenure_ctrl_tb.sv
module dbt_tenure_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BEATS      = 4;
  localparam int CW         = $clog2(BEATS);

  logic clk = 1'b0;
  logic rst, stream_mode, no_retry, req_valid, req_burst, req_read;
  logic grant_n, ext_busy_n, ack_n, retry_n;
  logic busy_n, take, done;
  logic [CW-1:0] beat;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Cycle model of the requirements.
  bit m_active, m_burst, m_read, m_take, m_done;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbt_tenure_ctrl #(.BURST_BEATS(BEATS)) u_dut (
    .clk (clk), .rst (rst), .stream_mode_i (stream_mode), .no_retry_i (no_retry),
    .req_valid_i (req_valid), .req_burst_i (req_burst), .req_read_i (req_read),
    .grant_n_i (grant_n), .ext_busy_n_i (ext_busy_n), .xfer_ack_n_i (ack_n),
    .retry_n_i (retry_n), .busy_n_o (busy_n), .take_o (take), .done_o (done),
    .beat_o (beat)
  );

  function automatic int beats_of(bit burst);
    return burst ? BEATS : 1;
  endfunction

  function automatic bit chain_ok(bit cur_b, bit cur_r);
    return stream_mode && !grant_n && req_valid && req_burst && req_read && cur_b && cur_r;
  endfunction

  always @(posedge clk) begin
    bit rty;
    if (rst) begin
      m_active = 0; m_cnt = 0; m_burst = 0; m_read = 0; m_take = 0; m_done = 0;
    end else begin
      m_take = 0; m_done = 0;
      rty = m_active && !no_retry && !retry_n;
      if (!m_active) begin
        if (req_valid && !grant_n && (stream_mode || ext_busy_n)) begin
          m_active = 1; m_cnt = 0; m_burst = req_burst; m_read = req_read; m_take = 1;
        end
      end else if (rty) begin
        m_cnt = 0;
      end else if (!ack_n) begin
        if (m_cnt == beats_of(m_burst) - 1) begin
          m_done = 1; m_cnt = 0;
          if (chain_ok(m_burst, m_read)) begin
            m_take = 1; m_burst = req_burst; m_read = req_read;
          end else begin
            m_active = 0;
          end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    check({tag, " busy_n"}, busy_n, !m_active);
    check({tag, " take"}, take, m_take);
    check({tag, " done"}, done, m_done);
    check({tag, " beat"}, beat, m_cnt);
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic quiet();
    req_valid = 0; req_burst = 0; req_read = 0; grant_n = 1;
    ext_busy_n = 1; ack_n = 1; retry_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; stream_mode = 0; no_retry = 0; quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy_n", busy_n, 1); check("R1 take", take, 0);
    check("R1 done", done, 0);     check("R1 beat", beat, 0);
    rst = 0;

    // R2: blocked by another master, then started.
    ext_busy_n = 0; grant_n = 0; req_valid = 1;
    cyc("R2 blocked");
    check("R2 blocked literal", busy_n, 1);
    ext_busy_n = 1;
    cyc("R2 start");
    check("R2 take literal", take, 1);
    quiet(); grant_n = 0;
    ack_n = 0;
    cyc("R6 single end");
    check("R6 single release", busy_n, 1);
    quiet();

    // R5: no grant, no start in either mode.
    req_valid = 1; cyc("R5 normal");
    stream_mode = 1; ext_busy_n = 0; cyc("R5 stream");
    check("R5 literal", busy_n, 1);

    // R11: acks and retries while idle.
    req_valid = 0; ack_n = 0; retry_n = 0;
    cyc("R11 idle ack"); cyc("R11 idle ack2");
    ack_n = 1; retry_n = 1;

    // R4: grant parked low, then a request arrives (R3: ext busy low).
    grant_n = 0;
    for (int i = 0; i < 5; i++) cyc("R4 parked");
    req_valid = 1; req_burst = 1; req_read = 1;
    cyc("R3 R4 stream start");
    check("R4 busy literal", busy_n, 0);
    req_valid = 0;
    for (int i = 1; i < BEATS; i++) begin
      ack_n = 0; cyc("R6 burst beat");
    end
    check("R6 beat literal", beat, BEATS - 1);
    // R7: final ack meets grant and pending burst read.
    req_valid = 1; req_burst = 1; req_read = 1;
    cyc("R7 chain");
    check("R7 busy held", busy_n, 0);
    check("R7 take", take, 1);
    req_valid = 0; ack_n = 1;

    // R9: retry clears the count.
    ack_n = 0; cyc("R9 pre");
    retry_n = 0; cyc("R9 retry");
    check("R9 beat literal", beat, 0);
    // R10: retry ignored in no-retry mode.
    no_retry = 1; cyc("R10 ignored");
    check("R10 beat literal", beat, 1);
    retry_n = 1; no_retry = 0;
    cyc("R6 beat"); cyc("R6 beat");
    // R8: pending burst write at final ack is not chained.
    req_valid = 1; req_burst = 1; req_read = 0;
    cyc("R8 no chain");
    check("R8 release", busy_n, 1);
    check("R8 take", take, 0);
    quiet(); stream_mode = 0;

    // R8: normal mode never chains.
    grant_n = 0; req_valid = 1; req_burst = 1; req_read = 1;
    cyc("R8 normal start");
    for (int i = 0; i < BEATS; i++) begin
      ack_n = 0; cyc("R8 normal beats");
    end
    check("R8 normal release", busy_n, 1);
    quiet();

    // Random phase against the model.
    for (int n = 0; n < 4000; n++) begin
      rst         = ($urandom_range(0, 199) == 0);
      if (($urandom_range(0, 63)) == 0) stream_mode = $urandom_range(0, 1);
      if (($urandom_range(0, 63)) == 0) no_retry = $urandom_range(0, 1);
      req_valid   = ($urandom_range(0, 3) != 0);
      req_burst   = $urandom_range(0, 1);
      req_read    = ($urandom_range(0, 3) != 0);
      grant_n     = ($urandom_range(0, 2) == 0);
      ext_busy_n  = ($urandom_range(0, 3) != 0);
      ack_n       = ($urandom_range(0, 2) == 0);
      retry_n     = ($urandom_range(0, 9) != 0);
      cyc("R2 R3 R6 R7 R9 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule